// File: doc/BRIEF.md
# Vector Operation Latency Calculator

This unit predicts how many cycles a vector operation will take. A request carries an operation code, an element count and seven unit latencies: reduction tree, scalar multiply, scalar square root, add, multiply, exponent and GELU. The block works out two counts. The first is the number of lane-wide vector passes. The second is the total number of reduction-tree passes. It then combines the two counts with the latencies in a formula chosen by the operation. The result appears together with a one-cycle done strobe.

The reduction count is found iteratively, one division level per clock. The element count is divided by the lane width, rounding up, and each quotient is added to a running total. This repeats until the quotient fits in a single pass, which adds one more. The lane width is a power-of-two parameter, so each division is a shift plus a test of the bits that are shifted out. The block only estimates latency and does not execute the operation.

Top module: `vlat_calc`

## Requirements
- R1: After reset, `busy` and `done` are low and `result` is 0.
- R2: A request is accepted on a rising edge where `req_valid` is high and `busy` is low. `busy` is high in the following cycle. A `req_valid` while `busy` is high is ignored: it produces no done pulse and does not change any later result.
- R3: The vector pass count V is the element count divided by LANES, rounded up. A count of 0 gives V = 0.
- R4: The tree pass count T is 1 when the element count n is at most LANES. Otherwise T = q + T(q), where q = ceil(n / LANES).
- R5: Let L be the number of levels, meaning the number of division steps plus 1. `done` is high for exactly one cycle, L rising edges after the accepting edge. `busy` is low in that same cycle.
- R6: Operation code 0 (normalization) yields 2·T·tree + 2·smul + sqrt + V·(2·add + 3·mul).
- R7: Operation code 1 (softmax) yields 2·T·tree + V·(add + exp + mul).
- R8: Operation code 2 (elementwise add) yields V·add. Operation code 3 (GELU) yields V·gelu.
- R9: Operation code 4 (placeholder) yields 1. Codes 5 to 7 yield 0.
- R10: The latencies are captured at acceptance. Changing the latency inputs while `busy` is high has no effect on the result.
- R11: `result` holds its value from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_size | input | SIZE_W | Element count |
| lat_tree | input | 16 | Reduction-tree pass latency |
| lat_smul | input | 16 | Scalar multiply latency |
| lat_sqrt | input | 16 | Scalar square-root latency |
| lat_add | input | 16 | Vector add latency |
| lat_mul | input | 16 | Vector multiply latency |
| lat_exp | input | 16 | Vector exponent latency |
| lat_gelu | input | 16 | Vector GELU latency |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | 32 | Predicted cycle count |

## Verification
Two things can happen in the same cycle: the done pulse for one request, and the arrival of the next request, since `busy` is already low while `done` is high. The driver issues each new request at the first falling edge where `busy` is low, which lands it in the done cycle of the previous request. The scoreboard then confirms two things for every request. The earlier result must still be correct and present. The new request must complete after its own expected number of levels, counted from that done cycle.

// File: rtl/vlat_pkg.sv
package vlat_pkg;

    localparam int LAT_W = 16;
    localparam int RES_W = 32;

    localparam logic [2:0] OP_NORM = 3'd0;
    localparam logic [2:0] OP_SMAX = 3'd1;
    localparam logic [2:0] OP_ADD  = 3'd2;
    localparam logic [2:0] OP_GELU = 3'd3;
    localparam logic [2:0] OP_NOP  = 3'd4;

    typedef struct packed {
        logic [LAT_W-1:0] tree;
        logic [LAT_W-1:0] smul;
        logic [LAT_W-1:0] sqrt;
        logic [LAT_W-1:0] add;
        logic [LAT_W-1:0] mul;
        logic [LAT_W-1:0] exp;
        logic [LAT_W-1:0] gelu;
    } lat_set_t;

    function automatic logic [RES_W-1:0] widen(input logic [LAT_W-1:0] v);
        return RES_W'(v);
    endfunction

    // Divide by 2**sh and round up: shift, then add one if any dropped bit was set.
    function automatic logic [RES_W-1:0] ceil_shift(input logic [RES_W-1:0] v,
                                                    input int unsigned sh);
        logic [RES_W-1:0] mask;
        mask = (RES_W'(1) << sh) - RES_W'(1);
        return (v >> sh) + ((|(v & mask)) ? RES_W'(1) : RES_W'(0));
    endfunction

endpackage

// File: rtl/vlat_tree_walk.sv
module vlat_tree_walk
    import vlat_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SIZE_W-1:0] size_i,
    output logic              busy_o,
    output logic              fin_o,
    output logic [RES_W-1:0]  total_o
);
    localparam int unsigned   SH      = $clog2(LANES);
    localparam logic [RES_W-1:0] LANES_R = RES_W'(LANES);

    logic             run_q;
    logic [RES_W-1:0] cur_q;
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] quot;
    logic             last;

    generate
        if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
            $error("LANES must be a power of two of at least 2");
        end
    endgenerate

    always_comb begin
        quot    = ceil_shift(cur_q, SH);
        last    = run_q && (cur_q <= LANES_R);
        fin_o   = last;
        busy_o  = run_q;
        total_o = acc_q + RES_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cur_q <= '0;
            acc_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cur_q <= RES_W'(size_i);
            acc_q <= '0;
        end else if (run_q) begin
            if (last) begin
                run_q <= 1'b0;
            end else begin
                cur_q <= quot;
                acc_q <= acc_q + quot;
            end
        end
    end

    // R4: each non-final level strictly reduces the remaining size
    a_r4_level_shrinks: assert property (@(posedge clk) disable iff (rst)
        (run_q && !last) |=> (cur_q < $past(cur_q)));

    // R4: each non-final level adds a nonzero quotient to the pass total
    a_r4_total_grows: assert property (@(posedge clk) disable iff (rst)
        (run_q && !last && !start) |=> (acc_q > $past(acc_q)));

endmodule

// File: rtl/vlat_cost_mix.sv
module vlat_cost_mix
    import vlat_pkg::*;
(
    input  logic [2:0]       op_i,
    input  lat_set_t         lat_i,
    input  logic [RES_W-1:0] tree_i,
    input  logic [RES_W-1:0] vec_i,
    output logic [RES_W-1:0] cost_o
);
    logic [RES_W-1:0] tree_part;
    logic [RES_W-1:0] scal_part;
    logic [RES_W-1:0] norm_vec;
    logic [RES_W-1:0] smax_vec;

    always_comb begin
        tree_part = RES_W'(2) * tree_i * widen(lat_i.tree);
        scal_part = RES_W'(2) * widen(lat_i.smul) + widen(lat_i.sqrt);
        norm_vec  = vec_i * (RES_W'(2) * widen(lat_i.add) + RES_W'(3) * widen(lat_i.mul));
        smax_vec  = vec_i * (widen(lat_i.add) + widen(lat_i.exp) + widen(lat_i.mul));
        case (op_i)
            OP_NORM: cost_o = tree_part + scal_part + norm_vec;
            OP_SMAX: cost_o = tree_part + smax_vec;
            OP_ADD:  cost_o = vec_i * widen(lat_i.add);
            OP_GELU: cost_o = vec_i * widen(lat_i.gelu);
            OP_NOP:  cost_o = RES_W'(1);
            default: cost_o = '0;
        endcase
    end

endmodule

// File: rtl/vlat_calc.sv
module vlat_calc
    import vlat_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [15:0]       lat_tree,
    input  logic [15:0]       lat_smul,
    input  logic [15:0]       lat_sqrt,
    input  logic [15:0]       lat_add,
    input  logic [15:0]       lat_mul,
    input  logic [15:0]       lat_exp,
    input  logic [15:0]       lat_gelu,
    output logic              busy,
    output logic              done,
    output logic [31:0]       result
);
    localparam int unsigned SH = $clog2(LANES);

    logic             walk_busy;
    logic             walk_fin;
    logic [RES_W-1:0] walk_total;
    logic             accept;
    logic [2:0]       op_q;
    lat_set_t         lat_q;
    lat_set_t         lat_in;
    logic [RES_W-1:0] vec_q;
    logic [RES_W-1:0] cost;
    logic             done_q;
    logic [RES_W-1:0] result_q;

    always_comb begin
        accept = req_valid && !walk_busy;
        lat_in = '{tree: lat_tree, smul: lat_smul, sqrt: lat_sqrt, add: lat_add,
                   mul: lat_mul, exp: lat_exp, gelu: lat_gelu};
    end

    vlat_tree_walk #(.LANES(LANES), .SIZE_W(SIZE_W)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .size_i  (req_size),
        .busy_o  (walk_busy),
        .fin_o   (walk_fin),
        .total_o (walk_total)
    );

    vlat_cost_mix u_mix (
        .op_i   (op_q),
        .lat_i  (lat_q),
        .tree_i (walk_total),
        .vec_i  (vec_q),
        .cost_o (cost)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= '0;
            lat_q    <= '0;
            vec_q    <= '0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= walk_fin;
            if (accept) begin
                op_q  <= req_op;
                lat_q <= lat_in;
                vec_q <= ceil_shift(RES_W'(req_size), SH);
            end
            if (walk_fin) begin
                result_q <= cost;
            end
        end
    end

    assign busy   = walk_busy;
    assign done   = done_q;
    assign result = result_q;

    // R2: an accepted request makes the unit busy in the next cycle
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: the unit is idle while done is shown
    a_r5_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: placeholder operation reports one cycle
    a_r9_placeholder_one: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OP_NOP) |-> (result == 32'd1));

    // R9: unrecognised operation codes report zero
    a_r9_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        (done && op_q > OP_NOP) |-> (result == 32'd0));

    // R11: the result is steady outside a done pulse
    a_r11_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

endmodule

// File: tb/vlat_calc_bench.sv
`timescale 1ns/1ps
module vlat_calc_bench;
    localparam int LN  = 8;
    localparam int SZW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [SZW-1:0] req_size = '0;
    logic [15:0] lat_tree = '0, lat_smul = '0, lat_sqrt = '0, lat_add = '0;
    logic [15:0] lat_mul = '0, lat_exp = '0, lat_gelu = '0;
    logic busy, done;
    logic [31:0] result;

    always #10 clk = ~clk;

    vlat_calc #(.LANES(LN), .SIZE_W(SZW)) u_vlat_calc (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_size(req_size), .lat_tree(lat_tree), .lat_smul(lat_smul),
        .lat_sqrt(lat_sqrt), .lat_add(lat_add), .lat_mul(lat_mul),
        .lat_exp(lat_exp), .lat_gelu(lat_gelu),
        .busy(busy), .done(done), .result(result)
    );

    typedef struct {
        logic [31:0] res;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t    sb[$];
    int      cyc = 0;
    int      checks = 0;
    int      fails = 0;
    logic [31:0] last_res = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [2:0] op, input int size,
                                  input int lt, input int ls, input int lq, input int la,
                                  input int lm, input int le, input int lg,
                                  output logic [31:0] res, output int levels);
        longint t = 0;
        longint s = size;
        longint v = (size + LN - 1) / LN;
        longint r;
        levels = 1;
        while (s > LN) begin
            s = (s + LN - 1) / LN;
            t += s;
            levels++;
        end
        t += 1;
        case (op)
            3'd0: r = 2*t*lt + 2*ls + lq + v*(2*la + 3*lm);
            3'd1: r = 2*t*lt + v*(la + le + lm);
            3'd2: r = v*la;
            3'd3: r = v*lg;
            3'd4: r = 1;
            default: r = 0;
        endcase
        res = r[31:0];
    endfunction

    // Driver: issues at the first falling edge with busy low (often the done cycle).
    task automatic issue(input logic [2:0] op, input int size,
                         input int lt, input int ls, input int lq, input int la,
                         input int lm, input int le, input int lg,
                         input string tag, input bit scramble, input bit poke);
        exp_t e;
        int lv;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_op = op; req_size = SZW'(size);
        lat_tree = 16'(lt); lat_smul = 16'(ls); lat_sqrt = 16'(lq); lat_add = 16'(la);
        lat_mul = 16'(lm); lat_exp = 16'(le); lat_gelu = 16'(lg);
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        model(op, size, lt, ls, lq, la, lm, le, lg, e.res, lv);
        e.cyc = cyc + lv;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        if (scramble) begin
            // R10: change every latency while the request is in flight
            lat_tree = 16'd77; lat_smul = 16'd55; lat_sqrt = 16'd33; lat_add = 16'd99;
            lat_mul = 16'd44; lat_exp = 16'd66; lat_gelu = 16'd88;
        end
        if (poke) begin
            // R2: a request while busy must be ignored
            req_op = 3'd4; req_size = SZW'(3); req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(result == e.res, e.tag, result, e.res);
                    check(cyc == e.cyc, "R5 done timing (R4 levels)", cyc, e.cyc);
                    check(!busy, "R5 busy low at done", busy, 0);
                end
                last_res = result;
            end else begin
                check(result == last_res, "R11 result hold", result, last_res);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0, "R1 busy reset", busy, 0);
        check(done == 1'b0, "R1 done reset", done, 0);
        check(result == 32'd0, "R1 result reset", result, 0);

        issue(3'd0, 1000, 3, 4, 9, 2, 5, 7, 11, "R6 norm large (R3 R4)", 1'b0, 1'b0);
        issue(3'd0, 8, 3, 4, 9, 2, 5, 7, 11, "R6 norm one lane (R4)", 1'b0, 1'b0);
        issue(3'd0, 9, 6, 1, 2, 3, 4, 5, 6, "R6 norm just over lane (R3 R4)", 1'b0, 1'b0);
        issue(3'd1, 64, 2, 0, 0, 3, 1, 8, 0, "R7 softmax", 1'b0, 1'b0);
        issue(3'd1, 300, 5, 1, 1, 2, 2, 9, 1, "R7 softmax", 1'b0, 1'b0);
        issue(3'd2, 17, 1, 1, 1, 6, 1, 1, 1, "R8 add (R3)", 1'b0, 1'b0);
        issue(3'd3, 0, 4, 4, 4, 4, 4, 4, 13, "R8 gelu zero size (R3)", 1'b0, 1'b0);
        issue(3'd3, 123, 4, 4, 4, 4, 4, 4, 13, "R8 gelu", 1'b0, 1'b0);
        issue(3'd4, 500, 9, 9, 9, 9, 9, 9, 9, "R9 placeholder", 1'b0, 1'b0);
        issue(3'd6, 40, 9, 9, 9, 9, 9, 9, 9, "R9 unknown code", 1'b0, 1'b0);
        issue(3'd7, 1, 9, 9, 9, 9, 9, 9, 9, "R9 unknown code", 1'b0, 1'b0);
        issue(3'd1, 300, 5, 1, 1, 2, 2, 9, 1, "R10 latencies captured", 1'b1, 1'b0);
        issue(3'd0, 4000, 3, 2, 7, 1, 2, 3, 4, "R10 norm latencies captured", 1'b1, 1'b0);
        issue(3'd0, 1000, 3, 4, 9, 2, 5, 7, 11, "R2 ignored while busy", 1'b0, 1'b1);
        issue(3'd1, 9, 3, 4, 9, 2, 5, 7, 11, "R2 ignored while busy", 1'b0, 1'b1);
        issue(3'd0, 65535, 65535, 65535, 65535, 65535, 65535, 65535, 65535,
              "R6 maximum size and latencies", 1'b0, 1'b0);

        @(negedge clk);
        while (busy || sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule